// File: doc/BRIEF.md
# Single-Word Clock Domain Crossing with Held Data and Ready Flag

This block carries one multi-bit word from a source clock domain into an unrelated receive clock domain. When the source strobes a load, the word goes into a holding register that runs on the source clock. Only one bit crosses to the receive side: a request toggle that passes through a chain of synchronizer flops. The receive side reports a word as ready once the toggle has come through. The receiver then reads the holding register directly. The register cannot change during this time, because the source side refuses new loads until the receiver has acknowledged the word.

The receiver acknowledges a word by asserting its read strobe while ready is high. The acknowledge is an acknowledge toggle that goes back through its own synchronizer into the source domain and releases busy there. Ready and busy are both formed by comparing two toggle levels, so no single-cycle pulse ever crosses a domain boundary. If the source attempts a load while busy, the block ignores the load and sets a sticky overrun flag. The block holds at most one word.

Top module: `word_cross_top`

## Requirements
- R1: While either reset is low, and directly after both are released, `dst_ready`, `src_busy` and `src_overrun` are 0.
- R2: A load strobe sampled on a source edge while `src_busy` is 0 captures `src_data`, and `src_busy` reads 1 after that same edge.
- R3: `dst_ready` stays 0 after the first receive edge that follows an accepted load. It reads 1 after the second such edge, because the request passes through two synchronizer flops.
- R4: Whenever `dst_ready` is 1, `dst_data` equals the last accepted word and does not change until the word is read.
- R5: A read strobe sampled on a receive edge while `dst_ready` is 1 consumes the word, and `dst_ready` reads 0 after that edge.
- R6: A read strobe sampled while `dst_ready` is 0 has no effect: `dst_ready` stays 0 and the next transfer behaves normally.
- R7: After a read, `src_busy` stays 1 past the first source edge and reads 0 after the second, because the acknowledge passes through two synchronizer flops. A new load is then accepted.
- R8: A load strobe sampled while `src_busy` is 1 is ignored, and the word later delivered is the one accepted earlier.
- R9: An ignored load sets `src_overrun`. The flag stays 1 until reset.
- R10: A read strobe held high continuously consumes each word exactly once. Ready is high for one receive cycle per word, so a full transfer spans at least three receive periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_load | input | 1 | Load strobe for a new word |
| src_data | input | DATA_W | Word to send |
| src_busy | output | 1 | A word is in flight; loads are refused |
| src_overrun | output | 1 | Sticky flag set when a load is refused |
| dst_clk | input | 1 | Receive domain clock |
| dst_rst_n | input | 1 | Receive domain asynchronous reset, active low |
| dst_read | input | 1 | Read strobe that acknowledges the held word |
| dst_ready | output | 1 | A word is waiting to be read |
| dst_data | output | DATA_W | Held word, valid while `dst_ready` is 1 |

## Verification
The hardest cases to reach from the ports are those that depend on the two clocks' relative phase: the exact cycle in which ready rises, and the cycle in which busy falls after the acknowledge has crossed back. The two clocks have unrelated periods whose edges never coincide, so the bench can count edges of the other domain from each event. Randomized idle gaps, read delays, stray reads and refused loads then move the transfers across many phase alignments. Directed passes hold the read strobe high continuously and strike a load in the middle of a transfer.

// File: rtl/wcx_pkg.sv
package wcx_pkg;
  // A toggle pair is pending when the two levels differ.
  function automatic logic tgl_pending(input logic near_t, input logic far_t);
    return near_t ^ far_t;
  endfunction

  // Advance a toggle level when an event fires.
  function automatic logic tgl_next(input logic cur, input logic fire);
    return cur ^ fire;
  endfunction
endpackage

// File: rtl/wcx_sync.sv
module wcx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[LAST];
endmodule

// File: rtl/wcx_src_side.sv
module wcx_src_side
  import wcx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              ack_tgl_async,
  output logic              busy,
  output logic              overrun,
  output logic [DATA_W-1:0] hold_q,
  output logic              req_tgl,
  output logic              ld_accept,
  output logic              ld_ignored
);
  logic ack_s;
  logic req_q;
  logic ovr_q;

  wcx_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ack_tgl_async),
    .q_sync  (ack_s)
  );

  assign busy       = tgl_pending(req_q, ack_s);
  assign ld_accept  = load & ~busy;
  assign ld_ignored = load & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      ovr_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      req_q <= tgl_next(req_q, ld_accept);
      if (ld_accept)  hold_q <= din;
      if (ld_ignored) ovr_q  <= 1'b1;
    end
  end

  assign req_tgl = req_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/wcx_dst_side.sv
module wcx_dst_side
  import wcx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl_async,
  input  logic read,
  output logic ready,
  output logic ack_tgl,
  output logic rd_ack
);
  logic req_s;
  logic ack_q;

  wcx_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (req_tgl_async),
    .q_sync  (req_s)
  );

  assign ready  = tgl_pending(req_s, ack_q);
  assign rd_ack = read & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= tgl_next(ack_q, rd_ack);
  end

  assign ack_tgl = ack_q;
endmodule

// File: rtl/word_cross_top.sv
module word_cross_top #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_load,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_busy,
  output logic              src_overrun,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  input  logic              dst_read,
  output logic              dst_ready,
  output logic [DATA_W-1:0] dst_data
);
  logic              req_tgl;
  logic              ack_tgl;
  logic              ld_accept;
  logic              ld_ignored;
  logic              rd_ack;
  logic [DATA_W-1:0] hold_q;

  wcx_src_side #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_src (
    .clk           (src_clk),
    .rst_n         (src_rst_n),
    .load          (src_load),
    .din           (src_data),
    .ack_tgl_async (ack_tgl),
    .busy          (src_busy),
    .overrun       (src_overrun),
    .hold_q        (hold_q),
    .req_tgl       (req_tgl),
    .ld_accept     (ld_accept),
    .ld_ignored    (ld_ignored)
  );

  wcx_dst_side #(.SYNC_STAGES(SYNC_STAGES)) i_dst (
    .clk           (dst_clk),
    .rst_n         (dst_rst_n),
    .req_tgl_async (req_tgl),
    .read          (dst_read),
    .ready         (dst_ready),
    .ack_tgl       (ack_tgl),
    .rd_ack        (rd_ack)
  );

  // The holding register is driven only from the source clock.
  assign dst_data = hold_q;
endmodule

// File: rtl/wcx_checker.sv
module wcx_checker #(
  parameter int DATA_W = 32
) (
  input logic              src_clk,
  input logic              src_rst_n,
  input logic              dst_clk,
  input logic              dst_rst_n,
  input logic              src_busy,
  input logic              src_overrun,
  input logic              ld_accept,
  input logic              ld_ignored,
  input logic [DATA_W-1:0] hold_q,
  input logic              dst_ready,
  input logic              rd_ack,
  input logic [DATA_W-1:0] dst_data
);
  AST_BUSY_AFTER_LOAD: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    ld_accept |=> src_busy); // R2

  AST_HOLD_FROZEN_WHILE_BUSY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_busy |=> $stable(hold_q)); // R4

  AST_READY_HOLDS_DATA: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (dst_ready && !rd_ack) |=> (dst_ready && $stable(dst_data))); // R4

  AST_READ_CLEARS_READY: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    rd_ack |=> !dst_ready); // R5

  AST_IGNORED_LOAD_FLAGS: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    ld_ignored |=> (src_overrun && $stable(hold_q))); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    src_overrun |=> src_overrun); // R9
endmodule

bind word_cross_top wcx_checker #(.DATA_W(DATA_W)) i_wcx_checker (
  .src_clk     (src_clk),
  .src_rst_n   (src_rst_n),
  .dst_clk     (dst_clk),
  .dst_rst_n   (dst_rst_n),
  .src_busy    (src_busy),
  .src_overrun (src_overrun),
  .ld_accept   (ld_accept),
  .ld_ignored  (ld_ignored),
  .hold_q      (hold_q),
  .dst_ready   (dst_ready),
  .rd_ack      (rd_ack),
  .dst_data    (dst_data)
);

// File: tb/test_word_cross_top.sv
`timescale 1ns/100ps
module test_word_cross_top;
  localparam int DW = 32;

  logic          src_clk = 1'b0;
  logic          dst_clk = 1'b0;
  logic          src_rst_n = 1'b0;
  logic          dst_rst_n = 1'b0;
  logic          src_load = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          dst_read = 1'b0;
  logic          src_busy, src_overrun, dst_ready;
  logic [DW-1:0] dst_data;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_ovr = 1'b0;

  always #4   src_clk = ~src_clk;  // 125 MHz source
  always #5.5 dst_clk = ~dst_clk;  // unrelated receive clock

  word_cross_top #(.DATA_W(DW), .SYNC_STAGES(2)) i_word_cross_top (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_load(src_load),
    .src_data(src_data), .src_busy(src_busy), .src_overrun(src_overrun),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_read(dst_read),
    .dst_ready(dst_ready), .dst_data(dst_data)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] other_word(input logic [DW-1:0] w);
    return ~w ^ 32'h5A5A_0001;
  endfunction

  // Load a word; optionally strike a refused load while busy.
  task automatic do_load(input logic [DW-1:0] w, input bit strike);
    @(negedge src_clk);
    src_load = 1'b1; src_data = w;
    @(posedge src_clk); #0.2;
    src_load = 1'b0;
    chk(src_busy == 1'b1, "R2 busy after load", DW'(src_busy), 1);
    if (strike) begin
      @(negedge src_clk);
      src_load = 1'b1; src_data = other_word(w);
      @(posedge src_clk); #0.2;
      src_load = 1'b0;
      exp_ovr = 1'b1;
      chk(src_overrun == 1'b1, "R9 overrun set", DW'(src_overrun), 1);
      for (int k = 0; k < 20 && !dst_ready; k++) @(posedge dst_clk);
      #0.2;
      chk(dst_ready == 1'b1, "R8 ready after refused load", DW'(dst_ready), 1);
      chk(dst_data == w, "R8 refused load kept first word", dst_data, w);
    end else begin
      @(posedge dst_clk); #0.2;
      chk(dst_ready == 1'b0, "R3 not ready after first edge", DW'(dst_ready), 0);
      @(posedge dst_clk); #0.2;
      chk(dst_ready == 1'b1, "R3 ready after second edge", DW'(dst_ready), 1);
    end
  endtask

  task automatic do_read(input logic [DW-1:0] w, input int delay);
    repeat (delay) @(posedge dst_clk);
    @(negedge dst_clk);
    chk(dst_ready == 1'b1, "R4 still ready before read", DW'(dst_ready), 1);
    chk(dst_data == w, "R4 held data", dst_data, w);
    dst_read = 1'b1;
    @(posedge dst_clk); #0.2;
    dst_read = 1'b0;
    chk(dst_ready == 1'b0, "R5 ready cleared by read", DW'(dst_ready), 0);
    @(posedge src_clk); #0.2;
    chk(src_busy == 1'b1, "R7 busy past first source edge", DW'(src_busy), 1);
    @(posedge src_clk); #0.2;
    chk(src_busy == 1'b0, "R7 busy released", DW'(src_busy), 0);
  endtask

  task automatic stray_reads(input int n);
    @(negedge dst_clk);
    dst_read = 1'b1;
    repeat (n) @(posedge dst_clk);
    #0.2;
    dst_read = 1'b0;
    @(posedge dst_clk); #0.2;
    chk(dst_ready == 1'b0, "R6 stray read ignored", DW'(dst_ready), 0);
    chk(src_busy == 1'b0, "R6 busy untouched by stray read", DW'(src_busy), 0);
  endtask

  initial begin : watchdog
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] w;
    void'($urandom(32'h1234_ABCD));
    #25;
    chk(dst_ready == 0 && src_busy == 0 && src_overrun == 0, "R1 in reset",
        {29'd0, dst_ready, src_busy, src_overrun}, 0);
    #5;
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    repeat (3) @(posedge src_clk);
    #0.2;
    chk(dst_ready == 0 && src_busy == 0 && src_overrun == 0, "R1 after reset",
        {29'd0, dst_ready, src_busy, src_overrun}, 0);

    // Directed corner words.
    do_load(32'h0000_0000, 1'b0); do_read(32'h0000_0000, 0);
    do_load(32'hFFFF_FFFF, 1'b0); do_read(32'hFFFF_FFFF, 3);
    stray_reads(2);

    // R10: read strobe held high across two transfers.
    @(negedge dst_clk); dst_read = 1'b1;
    for (int t = 0; t < 2; t++) begin
      w = $urandom;
      @(negedge src_clk); src_load = 1'b1; src_data = w;
      @(posedge src_clk); #0.2; src_load = 1'b0;
      @(posedge dst_clk); #0.2;
      chk(dst_ready == 1'b0, "R10 not yet ready", DW'(dst_ready), 0);
      @(posedge dst_clk); #0.2;
      chk(dst_ready == 1'b1, "R10 ready one cycle", DW'(dst_ready), 1);
      chk(dst_data == w, "R10 data under held read", dst_data, w);
      @(posedge dst_clk); #0.2;
      chk(dst_ready == 1'b0, "R10 consumed once", DW'(dst_ready), 0);
      repeat (2) @(posedge src_clk); #0.2;
      chk(src_busy == 1'b0, "R10 busy released", DW'(src_busy), 0);
      repeat (4) @(posedge dst_clk);
      #0.2;
      chk(dst_ready == 1'b0, "R10 no repeat delivery", DW'(dst_ready), 0);
    end
    @(negedge dst_clk); dst_read = 1'b0;

    // Constrained random transfers.
    for (int i = 0; i < 60; i++) begin
      bit strike;
      w = $urandom;
      strike = ($urandom % 5) == 0;
      repeat ($urandom % 4) @(posedge src_clk);
      if (($urandom % 4) == 0) stray_reads(1 + $urandom % 3);
      do_load(w, strike);
      do_read(w, $urandom % 5);
      chk(src_overrun == exp_ovr, "R9 overrun sticky", DW'(src_overrun), DW'(exp_ovr));
    end

    // Reset clears the sticky flag.
    @(negedge src_clk);
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    #20;
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    repeat (2) @(posedge src_clk);
    #0.2;
    chk(src_overrun == 1'b0, "R1 R9 overrun cleared by reset", DW'(src_overrun), 0);
    do_load(32'hA5A5_5A5A, 1'b0); do_read(32'hA5A5_5A5A, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule